// File: doc/BRIEF.md
# Open-Drain Clock/Data Line Control Register

This block is a single 32-bit control and status word that lets software bit-bang a two-wire serial bus (clock line plus data line) through open-drain pads. Software pulls a line low by making it an output that drives a stored zero. It lets a line go high by switching it back to an input, so that the external pull-up raises it. Because each line has its own byte lane in the word, and each direction and value field has its own write-enable strobe, one write can move a single line and leave the other line as it was.

Each lane also holds a pull-up disable bit. This bit is stored on every write, so a read-modify-write carries it through unchanged. The lane also returns the synchronized level of its pad. Software reads the real state of the wire through that bit, whatever direction the line is set to, and can therefore see clock stretching or contention on the bus. The block does no protocol sequencing and no timing generation.

Lane layout: the clock line uses bits 7:0 and the data line uses bits 15:8. Within a lane, bit 0 is the pull-up disable, bit 1 is the direction write-enable, bit 2 is the direction (1 = output), bit 3 is the value write-enable, bit 4 is the output value and bit 5 is the sampled input. All other bits read as zero.

Top module: `pinpair_gpio_reg`

## Requirements
- R1: After reset, both pad output enables and both pad output values are 0. Every stored field, including both pull-up disable bits, reads 0. The input bits read 1 until real pad samples have passed through the synchronizer.
- R2: A write with a lane's direction write-enable (bit 1) set and its direction bit (bit 2) clear makes that line's pad output enable 0 from the next clock. The stored value bit is left as it was.
- R3: A write with a lane's direction write-enable, direction and value write-enable bits set and its value bit (bit 4) clear makes that pad's output enable 1 and its output value 0 from the next clock.
- R4: A field whose write-enable is clear keeps its stored value on a write. A write that touches only one lane's strobes leaves the other line's direction and value unchanged.
- R5: A write with all four write-enable bits clear leaves both lines' direction and value unchanged, whatever the direction and value bits hold.
- R6: Every write stores lane bit 0 (pull-up disable) of both lanes. Those bits read back as written until the next write.
- R7: The write-enable bits (lane bits 1 and 3), lane bits 6 and 7, and bits 31:16 always read as 0.
- R8: Lane bit 5 returns that lane's pad input level as it was two clocks earlier, independent of the direction setting.
- R9: Each pad's output enable equals the stored direction bit of its line, and each pad's output value equals the stored value bit, as read back in lane bits 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register word |
| wr_data | input | 32 | Write data with per-field write-enable strobes |
| rd_data | output | 32 | Current register contents and sampled pad levels |
| pad_in | input | 2 | Pad levels: bit 0 clock line, bit 1 data line |
| pad_oe | output | 2 | Pad output enable (1 = drive), bit 0 clock, bit 1 data |
| pad_out | output | 2 | Pad output value, bit 0 clock, bit 1 data |

## Verification
The stimulus starts with directed writes: driving one line low, releasing it, and driving the other line. Each write uses strobes for one lane only, which separates per-lane masking from whole-word writes. Writes with all strobes clear but set direction and value bits, and an all-ones word, show whether the strobes really gate the fields and whether write-only bits leak into the read value. Pad-level toggles applied while a line is driven and while it is released expose the two-clock input latency and any coupling between direction and the input bit. A pseudo-random sweep of data and pad levels, compared every cycle against a behavioural model, then covers mixed strobe combinations.

// File: rtl/pinpair_pkg.sv
package pinpair_pkg;

  localparam int REG_W       = 32;
  localparam int LANE_STRIDE = 8;
  localparam int LANE_W      = 6;

  // Field offsets inside one lane
  localparam int OFS_PUD    = 0;
  localparam int OFS_DIR_WE = 1;
  localparam int OFS_DIR    = 2;
  localparam int OFS_VAL_WE = 3;
  localparam int OFS_VAL    = 4;
  localparam int OFS_IN     = 5;

  typedef struct packed {
    logic pud;
    logic dir;
    logic val;
  } line_state_t;

  // Next state of one line after a write carrying this lane
  function automatic line_state_t apply_write(line_state_t cur, logic [LANE_W-1:0] lane);
    line_state_t nxt;
    nxt     = cur;
    nxt.pud = lane[OFS_PUD];
    if (lane[OFS_DIR_WE]) nxt.dir = lane[OFS_DIR];
    if (lane[OFS_VAL_WE]) nxt.val = lane[OFS_VAL];
    return nxt;
  endfunction

  // Read image of one lane; strobe positions always return zero
  function automatic logic [LANE_W-1:0] lane_image(line_state_t s, logic sampled);
    logic [LANE_W-1:0] img;
    img          = '0;
    img[OFS_PUD] = s.pud;
    img[OFS_DIR] = s.dir;
    img[OFS_VAL] = s.val;
    img[OFS_IN]  = sampled;
    return img;
  endfunction

endpackage

// File: rtl/pinpair_bit_sync.sv
module pinpair_bit_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pinpair_line_ctl.sv
module pinpair_line_ctl
  import pinpair_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] lane_wr,
  output line_state_t       state,
  output logic              dir_hit,
  output logic              val_hit
);
  line_state_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= '0;
    else if (wr_en) state_q <= apply_write(state_q, lane_wr);
  end

  assign state   = state_q;
  assign dir_hit = wr_en & lane_wr[OFS_DIR_WE];
  assign val_hit = wr_en & lane_wr[OFS_VAL_WE];
endmodule

// File: rtl/pinpair_gpio_reg.sv
module pinpair_gpio_reg
  import pinpair_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     rd_data,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_oe,
  output logic [NUM_LINES-1:0] pad_out
);
  line_state_t          line_st [NUM_LINES];
  logic [NUM_LINES-1:0] line_dir;
  logic [NUM_LINES-1:0] line_val;
  logic [NUM_LINES-1:0] line_pud;
  logic [NUM_LINES-1:0] sync_in;
  logic [NUM_LINES-1:0] dir_hit;
  logic [NUM_LINES-1:0] val_hit;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int BASE = i * LANE_STRIDE;

    pinpair_line_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .lane_wr (wr_data[BASE +: LANE_W]),
      .state   (line_st[i]),
      .dir_hit (dir_hit[i]),
      .val_hit (val_hit[i])
    );

    pinpair_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in[i]),
      .q     (sync_in[i])
    );

    assign line_dir[i] = line_st[i].dir;
    assign line_val[i] = line_st[i].val;
    assign line_pud[i] = line_st[i].pud;
  end

  assign pad_oe  = line_dir;
  assign pad_out = line_val;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_LINES; i++)
      rd_data[i*LANE_STRIDE +: LANE_W] = lane_image(line_st[i], sync_in[i]);
  end
endmodule

// File: rtl/pinpair_gpio_reg_chk.sv
module pinpair_gpio_reg_chk
  import pinpair_pkg::*;
#(
  parameter int NUM_LINES   = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [REG_W-1:0]     wr_data,
  input logic [REG_W-1:0]     rd_data,
  input logic [NUM_LINES-1:0] pad_in,
  input logic [NUM_LINES-1:0] pad_oe,
  input logic [NUM_LINES-1:0] pad_out
);
  localparam int CW = $clog2(SYNC_STAGES + 1) + 1;

  logic [REG_W-1:0] strobe_mask;
  logic [REG_W-1:0] pud_mask;
  logic [REG_W-1:0] rsvd_mask;
  logic             any_strobe;
  logic [NUM_LINES-1:0] pad_dly [SYNC_STAGES];
  logic [CW-1:0]    since_rst;
  logic [NUM_LINES-1:0] rd_in;
  logic [NUM_LINES-1:0] rd_dir;
  logic [NUM_LINES-1:0] rd_val;

  always_comb begin
    strobe_mask = '0;
    pud_mask    = '0;
    rsvd_mask   = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      strobe_mask[i*LANE_STRIDE + OFS_DIR_WE] = 1'b1;
      strobe_mask[i*LANE_STRIDE + OFS_VAL_WE] = 1'b1;
      pud_mask[i*LANE_STRIDE + OFS_PUD]       = 1'b1;
      rsvd_mask[i*LANE_STRIDE + OFS_PUD]      = 1'b0;
      rsvd_mask[i*LANE_STRIDE + OFS_DIR]      = 1'b0;
      rsvd_mask[i*LANE_STRIDE + OFS_VAL]      = 1'b0;
      rsvd_mask[i*LANE_STRIDE + OFS_IN]       = 1'b0;
      rd_in[i]  = rd_data[i*LANE_STRIDE + OFS_IN];
      rd_dir[i] = rd_data[i*LANE_STRIDE + OFS_DIR];
      rd_val[i] = rd_data[i*LANE_STRIDE + OFS_VAL];
    end
    any_strobe = |(wr_data & strobe_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      for (int s = 0; s < SYNC_STAGES; s++) pad_dly[s] <= '0;
    end else begin
      if (since_rst < CW'(SYNC_STAGES)) since_rst <= since_rst + 1'b1;
      pad_dly[0] <= pad_in;
      for (int s = 1; s < SYNC_STAGES; s++) pad_dly[s] <= pad_dly[s-1];
    end
  end

  // R2
  release_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[OFS_DIR_WE] && !wr_data[OFS_DIR]) |=> !pad_oe[0]);

  // R3
  drive_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[OFS_DIR_WE] && wr_data[OFS_DIR] && wr_data[OFS_VAL_WE] && !wr_data[OFS_VAL])
    |=> (pad_oe[0] && !pad_out[0]));

  // R4
  masked_data_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[LANE_STRIDE + OFS_DIR_WE]) |=> $stable(pad_oe[1]));

  // R5
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_strobe) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R6
  pud_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & pud_mask) == ($past(wr_data) & pud_mask)));

  // R7
  strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data & (strobe_mask | rsvd_mask)) == '0));

  // R8
  input_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= CW'(SYNC_STAGES)) |-> (rd_in == pad_dly[SYNC_STAGES-1]));

  // R9
  pad_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe == rd_dir) && (pad_out == rd_val)));
endmodule

bind pinpair_gpio_reg pinpair_gpio_reg_chk #(
  .NUM_LINES   (NUM_LINES),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .pad_in  (pad_in),
  .pad_oe  (pad_oe),
  .pad_out (pad_out)
);

// File: tb/sim_pinpair_gpio_reg.sv
module sim_pinpair_gpio_reg;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  pad_in = 2'b11;
  logic [1:0]  pad_oe;
  logic [1:0]  pad_out;

  int vectors = 0;
  int miscompares = 0;

  // behavioural reference state
  bit   m_dir [2];
  bit   m_val [2];
  bit   m_pud [2];
  logic [1:0] pad_hist [$];
  string cur_req = "R1";

  always #(PERIOD/2) clk = ~clk;

  pinpair_gpio_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_dir[i] = 0; m_val[i] = 0; m_pud[i] = 0;
    end
    pad_hist = {2'b11, 2'b11};
  endtask

  task automatic model_clock();
    if (wr_en) begin
      for (int i = 0; i < 2; i++) begin
        int b = 8 * i;
        m_pud[i] = wr_data[b];
        if (wr_data[b+1]) m_dir[i] = wr_data[b+2];
        if (wr_data[b+3]) m_val[i] = wr_data[b+4];
      end
    end
    pad_hist.push_back(pad_in);
    void'(pad_hist.pop_front());
  endtask

  function automatic logic [31:0] expect_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 2; i++) begin
      w[8*i]     = m_pud[i];
      w[8*i + 2] = m_dir[i];
      w[8*i + 4] = m_val[i];
      w[8*i + 5] = pad_hist[0][i];
    end
    return w;
  endfunction

  task automatic compare();
    logic [31:0] ew = expect_word();
    logic [1:0]  eoe = {m_dir[1], m_dir[0]};
    logic [1:0]  eout = {m_val[1], m_val[0]};
    vectors++;
    if (rd_data !== ew || pad_oe !== eoe || pad_out !== eout) begin
      miscompares++;
      $display("FAIL %s: rd=%h oe=%b out=%b expected rd=%h oe=%b out=%b",
               cur_req, rd_data, pad_oe, pad_out, ew, eoe, eout);
    end
  endtask

  // called at a falling edge: apply inputs, clock, update model, compare at next falling edge
  task automatic step(input bit w, input logic [31:0] d, input logic [1:0] pads);
    wr_en = w; wr_data = d; pad_in = pads;
    @(posedge clk);
    model_clock();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    logic [1:0]  pads = 2'b11;
    model_reset();
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    step(0, '0, 2'b11);
    step(0, '0, 2'b11);

    cur_req = "R3";                       // clock line driven low
    step(1, 32'h0000_000E, 2'b10);
    cur_req = "R4";                       // data line driven low, clock untouched
    step(1, 32'h0000_0E00, 2'b00);
    cur_req = "R2";                       // release clock, data held
    step(1, 32'h0000_0002, 2'b01);
    cur_req = "R5";                       // no strobes, dir/val bits set
    step(1, 32'h0000_1415, 2'b01);
    step(0, '0, 2'b01);
    cur_req = "R6";                       // pull-up disable bits only
    step(1, 32'h0000_0101, 2'b11);
    step(1, rd_data, 2'b11);              // read-modify-write keeps them
    cur_req = "R9";                       // drive high value on both lines
    step(1, 32'h0000_1E1E, 2'b11);
    cur_req = "R8";                       // pad toggles while driven
    step(0, '0, 2'b00);
    step(0, '0, 2'b01);
    step(0, '0, 2'b10);
    step(1, 32'h0000_0202, 2'b11);        // released, keep toggling
    step(0, '0, 2'b00);
    step(0, '0, 2'b11);
    cur_req = "R7";                       // all-ones word
    step(1, 32'hFFFF_FFFF, 2'b11);
    step(0, '0, 2'b10);

    cur_req = "R4";                       // mixed strobes sweep
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pads = lfsr[17:16];
      step(lfsr[9], lfsr, pads);
    end

    cur_req = "R1";                       // reset mid-run
    wr_en = 0;
    rst_n = 1'b0;
    #1;
    model_reset();
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    step(0, '0, 2'b11);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule